// File: doc/BRIEF.md
# Regulation Control and Clock Monitor

This block is a 16-bit control word for a clock-regulation unit. The word is reached through a plain synchronous port: a write strobe with a whole-word data bus, and a read bus that always shows the current register contents. From that word the block drives a 6-bit trim value, a frequency select, a clock monitor pin, and a one-cycle start pulse toward the regulation engine.

A regulation run is requested by writing a 1 to the trigger bit. The trigger bit holds no state and always reads as 0. An accepted request loads a lockout counter, and the lockout window is set in clock cycles by a parameter. While the window runs, the busy output is high and further trigger writes are dropped. When the counter expires, the start pulse is issued.

The monitor pin carries the corrected 256 Hz or 1 Hz clock, or it is held low. The pin is registered. It changes its source only while both source clocks are low, so no pulse on the pin is ever cut short or started part way through.

Top module: `regctl_monitor`

## Requirements
- R1: After reset, rd_data, trim_o, freq_sel_o, mon_o, reg_start_o and lock_busy_o are all 0.
- R2: A write stores wr_data[5:0] as the trim value. It reads back on rd_data[5:0] and drives trim_o from the next cycle.
- R3: Bits 15..10, 7 and 6 of rd_data always read 0. Writes to those positions store nothing.
- R4: Bit 9 is the monitor frequency select (0 = 256 Hz source, 1 = 1 Hz source). Bit 8 is the monitor enable. Both are read/write and read back at the same positions. Bit 9 also drives freq_sel_o.
- R5: A write with bit 7 set while lock_busy_o is low raises lock_busy_o on the next cycle. lock_busy_o then stays high for exactly LOCK_CYCLES cycles.
- R6: reg_start_o is high for exactly one cycle, in the first cycle after lock_busy_o falls.
- R7: A write with bit 7 set while lock_busy_o is high is ignored. It does not extend the window and adds no start pulse.
- R8: A write with bit 7 clear starts no lockout and no start pulse.
- R9: A write that sets bit 7 during lockout still updates bits 9, 8 and 5..0.
- R10: With the enable set, mon_o follows the selected source one cycle late. With the enable clear, mon_o is 0 from the cycle after both sources are low.
- R11: mon_o rises only on a rise of a source and falls only on a fall of a source. Every high pulse on mon_o is therefore a whole high phase of one source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register word |
| fast_clk_i | input | 1 | Corrected 256 Hz clock, in the block's clock domain |
| slow_clk_i | input | 1 | Corrected 1 Hz clock, in the block's clock domain |
| trim_o | output | 6 | Trim value |
| freq_sel_o | output | 1 | Monitor frequency select |
| reg_start_o | output | 1 | One-cycle regulation start pulse |
| lock_busy_o | output | 1 | High while the trigger lockout runs |
| mon_o | output | 1 | Clock monitor pin |

## Verification
Register fields, freq_sel_o and trim_o are due one edge after the write. The bench drives each write on a falling edge and reads back on the next falling edge. lock_busy_o rises on the edge that accepts the trigger and stays high for LOCK_CYCLES samples. reg_start_o is expected on the sample at offset LOCK_CYCLES, so the bench counts busy samples and records the offset of the pulse, with retrigger writes placed at chosen offsets inside the window. mon_o is due one edge after the source value the design sampled, so the bench captures the sources on the rising edge and compares on the following falling edge. It also measures every high run on mon_o against the half periods of the sources.

// File: rtl/regmon_pkg.sv
package regmon_pkg;
    localparam int unsigned WORD_W   = 16;
    localparam int unsigned TRIM_W   = 6;
    localparam int unsigned FREQ_BIT = 9;
    localparam int unsigned EN_BIT   = 8;
    localparam int unsigned TRIG_BIT = 7;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FAST = 2'd1,
        SRC_SLOW = 2'd2
    } src_sel_t;

    typedef struct packed {
        logic              freq;
        logic              en;
        logic [TRIM_W-1:0] trim;
    } ctl_fields_t;
endpackage

// File: rtl/regmon_regfile.sv
module regmon_regfile
    import regmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctl_fields_t       fields,
    output logic              trig_req,
    output logic [WORD_W-1:0] rd_data
);
    ctl_fields_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (wr_en) begin
            f_d.freq = wr_data[FREQ_BIT];
            f_d.en   = wr_data[EN_BIT];
            f_d.trim = wr_data[TRIM_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    // Trigger is a request only; it holds no state.
    assign trig_req = wr_en && wr_data[TRIG_BIT];
    assign fields   = f_q;

    always_comb begin
        rd_data               = '0;
        rd_data[FREQ_BIT]     = f_q.freq;
        rd_data[EN_BIT]       = f_q.en;
        rd_data[TRIM_W-1:0]   = f_q.trim;
    end
endmodule

// File: rtl/regmon_lockout.sv
module regmon_lockout #(
    parameter int unsigned LOCK_CYCLES = 544
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_req,
    output logic busy,
    output logic start
);
    localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             start;
    } lock_state_t;

    lock_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (s_q.cnt != '0) begin
            s_d.cnt   = s_q.cnt - 1'b1;
            s_d.start = (s_q.cnt == CNT_W'(1));
        end else if (trig_req) begin
            s_d.cnt = CNT_W'(LOCK_CYCLES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy  = (s_q.cnt != '0);
    assign start = s_q.start;
endmodule

// File: rtl/regmon_mux.sv
module regmon_mux
    import regmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic freq,
    input  logic fast_clk_i,
    input  logic slow_clk_i,
    output logic mon
);
    typedef struct packed {
        src_sel_t sel;
        logic     mon;
    } mux_state_t;

    mux_state_t m_d, m_q;
    src_sel_t   target;

    always_comb begin
        if (!en)       target = SRC_NONE;
        else if (freq) target = SRC_SLOW;
        else           target = SRC_FAST;
    end

    always_comb begin
        m_d = m_q;
        // Hand over only in a quiet interval of both sources.
        if (!fast_clk_i && !slow_clk_i) m_d.sel = target;
        unique case (m_d.sel)
            SRC_FAST: m_d.mon = fast_clk_i;
            SRC_SLOW: m_d.mon = slow_clk_i;
            default:  m_d.mon = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '{sel: SRC_NONE, mon: 1'b0};
        else        m_q <= m_d;
    end

    assign mon = m_q.mon;
endmodule

// File: rtl/regctl_monitor.sv
module regctl_monitor #(
    parameter int unsigned CLK_HZ      = 32768,
    parameter int unsigned LOCK_CYCLES = (CLK_HZ * 166 + 9999) / 10000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        fast_clk_i,
    input  logic        slow_clk_i,
    output logic [5:0]  trim_o,
    output logic        freq_sel_o,
    output logic        reg_start_o,
    output logic        lock_busy_o,
    output logic        mon_o
);
    import regmon_pkg::*;

    ctl_fields_t fields;
    logic        trig_req;

    regmon_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .fields   (fields),
        .trig_req (trig_req),
        .rd_data  (rd_data)
    );

    regmon_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_req (trig_req),
        .busy     (lock_busy_o),
        .start    (reg_start_o)
    );

    regmon_mux u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (fields.en),
        .freq       (fields.freq),
        .fast_clk_i (fast_clk_i),
        .slow_clk_i (slow_clk_i),
        .mon        (mon_o)
    );

    assign trim_o     = fields.trim;
    assign freq_sel_o = fields.freq;
endmodule

// File: rtl/regmon_chk.sv
module regmon_chk #(
    parameter int unsigned LOCK_CYCLES = 544
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        fast_clk_i,
    input logic        slow_clk_i,
    input logic [5:0]  trim_o,
    input logic        freq_sel_o,
    input logic        reg_start_o,
    input logic        lock_busy_o,
    input logic        mon_o
);
    logic [31:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)           busy_run <= '0;
        else if (lock_busy_o) busy_run <= busy_run + 1;
        else                  busy_run <= '0;
    end

    AST_TRIM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> trim_o == $past(wr_data[5:0])); // R2
    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> rd_data[9:8] == $past(wr_data[9:8])); // R4
    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_busy_o) |-> $past(wr_en && wr_data[7])); // R5
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_busy_o && busy_run == LOCK_CYCLES - 1) |=> !lock_busy_o); // R5
    AST_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        lock_busy_o |-> busy_run < LOCK_CYCLES); // R7
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_start_o |=> !reg_start_o); // R6
    AST_START_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_start_o |-> ($past(lock_busy_o) && !lock_busy_o)); // R6
    AST_MON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[8] && !fast_clk_i && !slow_clk_i) |=> !mon_o); // R10
    AST_MON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon_o) |-> (($past(fast_clk_i) && !$past(fast_clk_i, 2)) ||
                          ($past(slow_clk_i) && !$past(slow_clk_i, 2)))); // R11
    AST_MON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mon_o) |-> ((!$past(fast_clk_i) && $past(fast_clk_i, 2)) ||
                          (!$past(slow_clk_i) && $past(slow_clk_i, 2)))); // R11
endmodule

bind regctl_monitor regmon_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (.*);

// File: tb/tb_regctl_monitor.sv
module tb_regctl_monitor;
    localparam int LOCK = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        fast_clk_i = 1'b0;
    logic        slow_clk_i = 1'b0;
    logic [5:0]  trim_o;
    logic        freq_sel_o, reg_start_o, lock_busy_o, mon_o;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  src_run = 1'b0;
    bit  track = 1'b0;
    bit  done = 1'b0;
    int  ph = 0;
    int  hl = 0;
    logic fast_cap = 1'b0, slow_cap = 1'b0;

    always #2 clk = ~clk;

    regctl_monitor #(.LOCK_CYCLES(LOCK)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .fast_clk_i(fast_clk_i), .slow_clk_i(slow_clk_i),
        .trim_o(trim_o), .freq_sel_o(freq_sel_o), .reg_start_o(reg_start_o),
        .lock_busy_o(lock_busy_o), .mon_o(mon_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Source clocks: 256 Hz stand-in has 2-cycle halves, 1 Hz stand-in 10-cycle halves.
    initial forever begin
        @(negedge clk);
        if (src_run) begin
            ph++;
            fast_clk_i = (ph % 4) >= 2;
            slow_clk_i = (ph % 20) >= 10;
        end
    end

    initial forever begin
        @(posedge clk);
        fast_cap <= fast_clk_i;
        slow_cap <= slow_clk_i;
    end

    // R11: every high run on the pin equals a full source half period.
    initial forever begin
        @(negedge clk);
        if (mon_o) hl++;
        else if (hl != 0) begin
            if (track) chk("R11 pulse width", (hl == 2 || hl == 10), 1);
            hl = 0;
        end
    end

    // Trigger, optionally retrigger at offset wr_k with data extra; check window and pulse.
    task automatic lock_run(input int wr_k, input logic [15:0] extra);
        int bcnt = 0, scnt = 0, spos = -1;
        wr(16'h0095);
        for (int k = 0; k < LOCK + 4; k++) begin
            if (lock_busy_o) bcnt++;
            if (reg_start_o) begin scnt++; spos = k; end
            if (k == wr_k) begin wr_en = 1'b1; wr_data = extra; end
            else begin wr_en = 1'b0; wr_data = '0; end
            @(negedge clk);
        end
        chk("R5/R7 busy length", bcnt, LOCK);
        chk("R6/R7 start count", scnt, 1);
        chk("R6 start position", spos, LOCK);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 trim", trim_o, 0);
        chk("R1 freq", freq_sel_o, 0);
        chk("R1 outputs", {reg_start_o, lock_busy_o, mon_o}, 0);

        // Sweep all patterns of bits 15..6 with varied trim values.
        for (int i = 0; i < 1024; i++) begin
            logic [15:0] d;
            d = {i[9:0], 6'((i * 37) & 63)};
            wr(d);
            chk("R3/R4 readback", rd_data, d & 16'h033F);
            chk("R2 trim", trim_o, d[5:0]);
            chk("R4 freq", freq_sel_o, d[9]);
        end
        idle(LOCK + 3);

        // R8: trigger bit clear does nothing.
        begin
            int seen = 0;
            wr(16'h0015);
            for (int k = 0; k < LOCK + 3; k++) begin
                if (lock_busy_o || reg_start_o) seen++;
                @(negedge clk);
            end
            chk("R8 no lockout", seen, 0);
        end

        lock_run(-1, 16'h0000);
        idle(2);
        lock_run(2, 16'h02BF);
        chk("R9 fields during lockout", rd_data, 16'h023F);
        chk("R9 trim during lockout", trim_o, 6'h3F);
        idle(2);
        lock_run(LOCK - 1, 16'h01AA);
        chk("R9 fields late write", rd_data, 16'h012A);
        idle(2);

        // Monitor path.
        track = 1'b1;
        wr(16'h0100);
        src_run = 1'b1;
        idle(20);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            chk("R10 follows 256 Hz", mon_o, fast_cap);
        end
        wr(16'h0300);
        idle(30);
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            chk("R10 follows 1 Hz", mon_o, slow_cap);
        end
        wr(16'h0200);
        idle(30);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R10 disabled low", mon_o, 0);
        end
        for (int p = 0; p < 12; p++) begin
            wr((p % 3 == 0) ? 16'h0000 : ((p % 2 == 1) ? 16'h0300 : 16'h0100));
            idle(p + 3);
        end
        wr(16'h0000);
        idle(30);
        chk("R10 final low", mon_o, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule